// File: doc/BRIEF.md
# Buffered HDLC Data-Link Transmitter

This block sends one data-link message as a bit-stuffed HDLC frame. A processor first loads an 86-byte message store through a small byte-wide register port. Location 0 must already hold the flag byte 0x7E. The processor then writes the start bit in the control register. The block sends the opening flag from location 0 as it is. It then sends locations 1 to 85 and a 16-bit frame check sequence with zero insertion, and ends with a closing flag.

Bits leave one at a time, and only when the bit-slot strobe `bitSlot` is high. The strobe marks the data-link bit positions of a framed outbound stream that is built elsewhere. Between strobes the serial output holds its last value. While a frame is in progress the busy bit reads 1. When the last bit of the closing flag has gone out, the block sets an interrupt status bit, and it pulls the active-low interrupt output low if interrupts are enabled. A read of the control register clears the status bit.

Top module: `hdlc_dl_tx`

## Requirements
- R1: Writes to addresses 0 to 85 store a byte in the message store. A read of the same address returns that byte on `rdData` in the same cycle.
- R2: Address 86 is the control register. Bit 0 is start (write-only, reads 0), bit 1 is busy (read-only), bit 2 is interrupt enable and bit 3 is interrupt status. Writing a 1 to bit 0 while idle starts a frame. Busy reads 1 from the next cycle until the cycle after the last bit of the closing flag has been emitted.
- R3: A frame is sent in this order: the byte at location 0 with no zero insertion, then locations 1 to 85, then the FCS low byte, then the FCS high byte, then 0x7E with no zero insertion. Every byte is sent LSB first.
- R4: In locations 1 to 85 and in the FCS, a 0 is inserted after every five consecutive 1 bits, including a run that ends on the last FCS bit. The ones count restarts at the start of every frame.
- R5: The FCS is CRC-16 with polynomial x^16+x^12+x^5+1, preset 0xFFFF. It is computed LSB first over all 86 locations, including location 0, and sent ones-complemented.
- R6: Each cycle where `bitSlot` is high during a frame moves exactly one bit to `txOut`. When the strobe is low, `txOut` holds its value. After reset `txOut` is 1.
- R7: On the edge that emits the last bit of the closing flag, the status bit becomes 1. `irqN` is 0 whenever both status and enable are 1.
- R8: A read of the control register clears the status bit. `irqN` returns to 1 when status is cleared or when enable is written to 0.
- R9: A start write that arrives while busy is ignored. The frame in progress goes on unchanged.
- R10: After reset, busy, enable and status are 0 and `irqN` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (read of control clears status) |
| addr | input | 7 | Register address: 0 to 85 store, 86 control |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr`, combinational |
| bitSlot | input | 1 | Bit-slot strobe, one output bit per high cycle |
| txOut | output | 1 | Serial frame output |
| irqN | output | 1 | Completion interrupt, active low |

## Verification
The checker watches four things on every cycle. `txOut` holds when there is no strobe. A frame never shows more than six 1 bits in a row. Busy rises only after a start write. Status rises only at the end of a frame. Stuffing placement, the FCS value, bit order and the exact length of each frame are compared bit by bit in the bench scenarios, against a model of the frame built from the store contents. The same scenarios cover the read-to-clear and enable-release behaviour of the interrupt.

// File: rtl/hdlc_dl_pkg.sv
package hdlc_dl_pkg;

  localparam logic [7:0]  FLAG_BYTE = 8'h7E;
  localparam logic [15:0] CRC_PRESET = 16'hFFFF;
  // x^16+x^12+x^5+1, bit-reversed for LSB-first processing
  localparam logic [15:0] CRC_POLY_REV = 16'h8408;
  localparam int          RUN_LIMIT = 5;

  // control register bit positions
  localparam int CB_START  = 0;
  localparam int CB_BUSY   = 1;
  localparam int CB_IRQEN  = 2;
  localparam int CB_IRQST  = 3;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_OPEN,
    PH_BODY,
    PH_FCS,
    PH_CLOSE
  } phase_e;

  typedef enum logic [1:0] {
    SRC_STORE,
    SRC_FCS,
    SRC_FLAG
  } src_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       load;       // new frame: preset CRC, clear ones run
    logic       emitBit;    // shift out the selected bit
    logic       stuffZero;  // shift out an inserted zero
    logic       crcUpd;     // fold emitted bit into CRC
    logic       countOnes;  // emitted bit takes part in stuffing
    src_e       src;
    logic [2:0] bitSel;
  } dpCmd_t;

endpackage

// File: rtl/hdlc_dl_datapath.sv
module hdlc_dl_datapath
  import hdlc_dl_pkg::*;
#(
  parameter int BUF_BYTES = 86,
  parameter int IDX_W     = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             storeWr,
  input  logic [IDX_W-1:0] storeAddr,
  input  logic [7:0]       storeData,
  output logic [7:0]       storeRdData,
  input  dpCmd_t           cmd,
  input  logic [IDX_W-1:0] byteSel,
  output logic             onesFull,
  output logic             txBit
);

  localparam int RUN_W = $clog2(RUN_LIMIT + 1);

  logic [7:0]       store [BUF_BYTES];
  logic [15:0]      crc;
  logic [RUN_W-1:0] onesRun;
  logic [7:0]       curByte;
  logic [7:0]       storeByte;
  logic [15:0]      fcsWord;
  logic             curBit;

  function automatic logic [15:0] crcStep(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    return {1'b0, c[15:1]} ^ (fb ? CRC_POLY_REV : 16'h0000);
  endfunction

  // message store, one write port and two read ports
  genvar gi;
  generate
    for (gi = 0; gi < BUF_BYTES; gi++) begin : g_loc
      always_ff @(posedge clk) begin
        if (storeWr && (storeAddr == IDX_W'(gi)))
          store[gi] <= storeData;
      end
    end
  endgenerate

  always_comb begin
    storeRdData = 8'h00;
    storeByte   = 8'h00;
    for (int i = 0; i < BUF_BYTES; i++) begin
      if (storeAddr == IDX_W'(i)) storeRdData = store[i];
      if (byteSel == IDX_W'(i))   storeByte   = store[i];
    end
  end

  assign fcsWord = ~crc;

  always_comb begin
    unique case (cmd.src)
      SRC_STORE: curByte = storeByte;
      SRC_FCS:   curByte = byteSel[0] ? fcsWord[15:8] : fcsWord[7:0];
      default:   curByte = FLAG_BYTE;
    endcase
    curBit = curByte[cmd.bitSel];
  end

  assign onesFull = (onesRun == RUN_W'(RUN_LIMIT));

  always_ff @(posedge clk) begin
    if (rst) begin
      crc     <= CRC_PRESET;
      onesRun <= '0;
      txBit   <= 1'b1;
    end else if (cmd.load) begin
      crc     <= CRC_PRESET;
      onesRun <= '0;
    end else if (cmd.stuffZero) begin
      txBit   <= 1'b0;
      onesRun <= '0;
    end else if (cmd.emitBit) begin
      txBit <= curBit;
      if (cmd.crcUpd)
        crc <= crcStep(crc, curBit);
      if (cmd.countOnes && curBit)
        onesRun <= onesRun + 1'b1;
      else
        onesRun <= '0;
    end
  end

endmodule

// File: rtl/hdlc_dl_ctrl.sv
module hdlc_dl_ctrl
  import hdlc_dl_pkg::*;
#(
  parameter int BUF_BYTES = 86,
  parameter int IDX_W     = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrlWr,
  input  logic             ctrlRd,
  input  logic             wrStart,
  input  logic             wrIrqEn,
  input  logic             bitSlot,
  input  logic             onesFull,
  output dpCmd_t           cmd,
  output logic [IDX_W-1:0] byteSel,
  output logic             busy,
  output logic             irqEn,
  output logic             irqStatus,
  output logic             irqN
);

  localparam logic [IDX_W-1:0] LAST_LOC  = IDX_W'(BUF_BYTES - 1);
  localparam logic [IDX_W-1:0] FIRST_MSG = IDX_W'(1);

  phase_e           phase;
  logic [2:0]       bitIdx;
  logic [IDX_W-1:0] byteIdx;
  logic             startReq;
  logic             stuffPhase;
  logic             lastBit;
  logic             frameDone;

  assign busy       = (phase != PH_IDLE);
  assign startReq   = ctrlWr && wrStart && !busy;
  assign stuffPhase = (phase == PH_BODY) || (phase == PH_FCS) || (phase == PH_CLOSE);
  assign lastBit    = (bitIdx == 3'd7);
  assign byteSel    = byteIdx;

  always_comb begin
    cmd           = '0;
    cmd.load      = startReq;
    cmd.bitSel    = bitIdx;
    cmd.crcUpd    = (phase == PH_OPEN) || (phase == PH_BODY);
    cmd.countOnes = (phase == PH_BODY) || (phase == PH_FCS);
    unique case (phase)
      PH_FCS:   cmd.src = SRC_FCS;
      PH_CLOSE: cmd.src = SRC_FLAG;
      default:  cmd.src = SRC_STORE;
    endcase
    if (bitSlot && busy) begin
      if (stuffPhase && onesFull) cmd.stuffZero = 1'b1;
      else                        cmd.emitBit   = 1'b1;
    end
  end

  assign frameDone = cmd.emitBit && lastBit && (phase == PH_CLOSE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      bitIdx  <= '0;
      byteIdx <= '0;
    end else if (startReq) begin
      phase   <= PH_OPEN;
      bitIdx  <= '0;
      byteIdx <= '0;
    end else if (cmd.emitBit) begin
      bitIdx <= bitIdx + 1'b1;
      if (lastBit) begin
        unique case (phase)
          PH_OPEN: begin
            phase   <= PH_BODY;
            byteIdx <= FIRST_MSG;
          end
          PH_BODY: begin
            if (byteIdx == LAST_LOC) begin
              phase   <= PH_FCS;
              byteIdx <= '0;
            end else begin
              byteIdx <= byteIdx + 1'b1;
            end
          end
          PH_FCS: begin
            if (byteIdx[0]) begin
              phase   <= PH_CLOSE;
              byteIdx <= '0;
            end else begin
              byteIdx <= byteIdx + 1'b1;
            end
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irqEn     <= 1'b0;
      irqStatus <= 1'b0;
    end else begin
      if (ctrlWr)
        irqEn <= wrIrqEn;
      if (frameDone)
        irqStatus <= 1'b1;
      else if (ctrlRd)
        irqStatus <= 1'b0;
    end
  end

  assign irqN = !(irqStatus && irqEn);

endmodule

// File: rtl/hdlc_dl_tx.sv
module hdlc_dl_tx
  import hdlc_dl_pkg::*;
#(
  parameter int BUF_BYTES = 86,
  parameter int ADDR_W    = $clog2(BUF_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  input  logic              bitSlot,
  output logic              txOut,
  output logic              irqN
);

  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(BUF_BYTES);

  dpCmd_t            cmd;
  logic [ADDR_W-1:0] byteSel;
  logic              onesFull;
  logic              busy;
  logic              irqEn;
  logic              irqStatus;
  logic [7:0]        storeRdData;
  logic              ctrlSel;
  logic              storeSel;
  logic [7:0]        ctrlWord;

  assign ctrlSel  = (addr == CTRL_ADDR);
  assign storeSel = (addr < CTRL_ADDR);

  always_comb begin
    ctrlWord           = 8'h00;
    ctrlWord[CB_BUSY]  = busy;
    ctrlWord[CB_IRQEN] = irqEn;
    ctrlWord[CB_IRQST] = irqStatus;
  end

  assign rdData = ctrlSel ? ctrlWord : (storeSel ? storeRdData : 8'h00);

  hdlc_dl_ctrl #(.BUF_BYTES(BUF_BYTES), .IDX_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .ctrlWr   (wrEn && ctrlSel),
    .ctrlRd   (rdEn && ctrlSel),
    .wrStart  (wrData[CB_START]),
    .wrIrqEn  (wrData[CB_IRQEN]),
    .bitSlot  (bitSlot),
    .onesFull (onesFull),
    .cmd      (cmd),
    .byteSel  (byteSel),
    .busy     (busy),
    .irqEn    (irqEn),
    .irqStatus(irqStatus),
    .irqN     (irqN)
  );

  hdlc_dl_datapath #(.BUF_BYTES(BUF_BYTES), .IDX_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .storeWr    (wrEn && storeSel),
    .storeAddr  (addr),
    .storeData  (wrData),
    .storeRdData(storeRdData),
    .cmd        (cmd),
    .byteSel    (byteSel),
    .onesFull   (onesFull),
    .txBit      (txOut)
  );

endmodule

// File: rtl/hdlc_dl_tx_chk.sv
module hdlc_dl_tx_chk #(
  parameter int BUF_BYTES = 86,
  parameter int ADDR_W    = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wrData,
  input logic              bitSlot,
  input logic              txOut,
  input logic              busy,
  input logic              irqStatus
);

  logic       startWr;
  logic       slotSeen;
  logic [7:0] runLen;

  assign startWr = wrEn && (addr == ADDR_W'(BUF_BYTES)) && wrData[0];

  // R6: output only moves on a strobe
  a_r6_hold_between_slots: assert property (@(posedge clk) disable iff (rst)
    !bitSlot |=> $stable(txOut));

  // R2: a frame begins only after a start write
  a_r2_busy_needs_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(startWr));

  // R7: status rises only as a frame completes
  a_r7_status_at_end: assert property (@(posedge clk) disable iff (rst)
    $rose(irqStatus) |-> $fell(busy));

  // R9: a start write while busy does not end or restart the frame
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy && startWr && !bitSlot) |=> busy);

  // R4: run of ones on the line never exceeds a flag's six
  always_ff @(posedge clk) begin
    if (rst) begin
      slotSeen <= 1'b0;
      runLen   <= '0;
    end else begin
      slotSeen <= bitSlot && busy;
      if (slotSeen)
        runLen <= txOut ? ((runLen == 8'hFF) ? runLen : runLen + 1'b1) : 8'h00;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst)
      a_r4_run_limit: assert (runLen <= 8'd6);
  end

endmodule

bind hdlc_dl_tx hdlc_dl_tx_chk #(.BUF_BYTES(BUF_BYTES), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wrEn     (wrEn),
  .addr     (addr),
  .wrData   (wrData),
  .bitSlot  (bitSlot),
  .txOut    (txOut),
  .busy     (busy),
  .irqStatus(irqStatus)
);

// File: tb/sim_hdlc_dl_tx.sv
module sim_hdlc_dl_tx;

  localparam int BUF_BYTES = 86;
  localparam int ADDR_W    = 7;
  localparam int CTRL      = 86;
  localparam int MAXBITS   = 2000;

  logic clk = 1'b0;
  logic rst;
  logic wrEn, rdEn, bitSlot;
  logic [ADDR_W-1:0] addr;
  logic [7:0] wrData;
  logic [7:0] rdData;
  logic txOut, irqN;

  always #5 clk = ~clk;

  hdlc_dl_tx #(.BUF_BYTES(BUF_BYTES), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .bitSlot(bitSlot),
    .txOut(txOut), .irqN(irqN)
  );

  int nChk = 0;
  int nFail = 0;
  logic [7:0] img [BUF_BYTES];
  bit expBits [MAXBITS];
  int expLen;

  task automatic chk(string tag, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(int a, logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = ADDR_W'(a); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(int a, output logic [7:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = ADDR_W'(a);
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  function automatic void pushBit(bit b);
    expBits[expLen] = b;
    expLen++;
  endfunction

  // independent frame model: CRC in normal (MSB-aligned) form on reversed data
  function automatic void buildModel();
    logic [15:0] c;
    logic [15:0] fcs;
    logic [7:0]  v;
    int ones;
    c = 16'hFFFF;
    for (int i = 0; i < BUF_BYTES; i++)
      for (int b = 0; b < 8; b++) begin
        bit top;
        top = c[15] ^ img[i][b];
        c = {c[14:0], 1'b0};
        if (top) c = c ^ 16'h1021;
      end
    // reflect result so that bit order matches LSB-first transmission
    for (int b = 0; b < 16; b++) fcs[b] = ~c[15-b];
    expLen = 0;
    for (int b = 0; b < 8; b++) pushBit(img[0][b]);
    ones = 0;
    for (int k = 1; k < BUF_BYTES + 2; k++) begin
      v = (k < BUF_BYTES) ? img[k] : ((k == BUF_BYTES) ? fcs[7:0] : fcs[15:8]);
      for (int b = 0; b < 8; b++) begin
        pushBit(v[b]);
        ones = v[b] ? ones + 1 : 0;
        if (ones == 5) begin
          pushBit(1'b0);
          ones = 0;
        end
      end
    end
    for (int b = 0; b < 8; b++) pushBit(((8'h7E >> b) & 1) != 0);
  endfunction

  task automatic loadStore(int pattern);
    for (int i = 0; i < BUF_BYTES; i++) begin
      case (pattern)
        0: img[i] = 8'((i * 37 + 11) & 8'hFF);
        1: img[i] = 8'hFF;
        2: img[i] = 8'h00;
        default: img[i] = 8'h7E;
      endcase
      if (i == 0) img[i] = 8'h7E;
      busWrite(i, img[i]);
    end
    buildModel();
  endtask

  // sends one frame; checks every bit, busy and completion
  task automatic runFrame(string tag, int pattern, int gap, bit ie, int restartAt);
    logic [7:0] r;
    bit held;
    loadStore(pattern);
    busWrite(CTRL, ie ? 8'h05 : 8'h01);
    busRead(CTRL, r);
    chk({tag, " R2 busy after start"}, r[1], 1);
    for (int n = 0; n < expLen; n++) begin
      if (n == restartAt) begin
        busWrite(CTRL, ie ? 8'h05 : 8'h01);  // R9 start while busy
        busRead(CTRL, r);
        chk({tag, " R9 still busy after second start"}, r[1], 1);
      end
      if (n == expLen - 1) begin
        busRead(CTRL, r);
        chk({tag, " R2 busy before last bit"}, r[1], 1);
        chk({tag, " R7 no irq before last bit"}, irqN, 1);
      end
      @(negedge clk); bitSlot = 1'b1;
      @(negedge clk); bitSlot = 1'b0;
      chk($sformatf("%s R3/R4/R5 bit %0d", tag, n), txOut, expBits[n]);
      held = txOut;
      repeat (gap) @(negedge clk);
      if (gap > 0 && n < 24)
        chk($sformatf("%s R6 hold bit %0d", tag, n), txOut, held);
    end
    chk({tag, " R7 irqN at end"}, irqN, ie ? 0 : 1);
    busRead(CTRL, r);
    chk({tag, " R2 idle and R7 status after frame"}, r, ie ? 8'h0C : 8'h08);
    busRead(CTRL, r);
    chk({tag, " R8 status cleared by read"}, r, ie ? 8'h04 : 8'h00);
    chk({tag, " R8 irqN released"}, irqN, 1);
  endtask

  task automatic t_reset();
    logic [7:0] r;
    chk("R6 txOut idle after reset", txOut, 1);
    chk("R10 irqN after reset", irqN, 1);
    busRead(CTRL, r);
    chk("R10 control after reset", r, 8'h00);
  endtask

  task automatic t_store_rw();
    logic [7:0] r;
    busWrite(0, 8'h7E);
    busWrite(42, 8'hA5);
    busWrite(85, 8'h3C);
    busRead(42, r);  chk("R1 readback loc 42", r, 8'hA5);
    busRead(85, r);  chk("R1 readback loc 85", r, 8'h3C);
    busRead(0, r);   chk("R1 readback loc 0", r, 8'h7E);
  endtask

  task automatic t_enable_release();
    logic [7:0] r;
    runFrameNoClear();
    chk("R7 irqN low with enable", irqN, 0);
    busWrite(CTRL, 8'h00);
    #1 chk("R8 irqN released by enable off", irqN, 1);
    busRead(CTRL, r);
    chk("R8 status kept until read", r, 8'h08);
    busRead(CTRL, r);
    chk("R8 status cleared", r, 8'h00);
  endtask

  task automatic runFrameNoClear();
    loadStore(0);
    busWrite(CTRL, 8'h05);
    for (int n = 0; n < expLen; n++) begin
      @(negedge clk); bitSlot = 1'b1;
      @(negedge clk); bitSlot = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL R6 watchdog: got timeout expected frame completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    rst = 1'b1; wrEn = 1'b0; rdEn = 1'b0; bitSlot = 1'b0;
    addr = '0; wrData = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_store_rw();
    runFrame("ramp", 0, 1, 1'b1, -1);
    runFrame("ones", 1, 3, 1'b0, -1);
    runFrame("zeros", 2, 0, 1'b1, -1);
    runFrame("flags", 3, 2, 1'b1, 50);
    t_enable_release();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule